// File: doc/BRIEF.md
# Three-Stage Pipelined Floating-Point Adder

This block adds two single-precision floating-point operands. One operation can enter on every clock cycle, so as many as three operations can be in flight at once. Each operation passes through three registered stages. The first stage lines up the exponents, the second adds or subtracts the significands, and the third normalizes the result. The result, its valid flag and two status flags appear three clock edges after the operation is accepted.

Operands are 32-bit words: sign in bit 31, an 8-bit biased exponent in bits 30..23, and a 23-bit fraction in bits 22..0. A normalized operand has a hidden leading 1. Only normalized values and zeros are legal inputs. Any other encoding is reported on a flag and is not computed. Bits lost to alignment and normalization are truncated. The alignment-inexact flag reports whether alignment dropped any 1 bit.

Top module: `fpAddPipe`

## Requirements
- R1: An operation accepted with `inValid` high at a clock edge produces `outValid` high after exactly three clock edges. Operations may arrive back to back, and idle cycles produce `outValid` low in the matching slot.
- R2: Synchronous active-high reset clears every stage. After a reset edge `outValid` is low, and operations in flight when reset was applied never appear. While `outValid` is low, `outInexact` and `outBad` are low.
- R3: For operands of equal sign, the result has that sign and the truncated sum of the significands. A carry out of the hidden position shifts the result right by one and raises the exponent by one.
- R4: For operands of opposite sign, the result takes the sign of the larger-magnitude operand and the truncated magnitude difference. An exact cancellation gives +0 (0x00000000).
- R5: When the exponents differ, the significand of the smaller-exponent operand is shifted right by the exponent difference before the add, and the bits shifted out are discarded.
- R6: `outInexact` is high exactly when a 1 bit was shifted out during alignment. A shift of 24 or more removes the whole significand, including the hidden bit. Equal exponents never set the flag.
- R7: After a subtraction, the result is shifted left until its leading 1 reaches the hidden position, and the exponent is lowered by the same count.
- R8: An operand with exponent field 255, or with exponent field 0 and a nonzero fraction, is illegal. The operation then gives `outBad` high, `outSum` of 0 and `outInexact` low.
- R9: An operand with exponent field 0 and fraction 0 is zero, of either sign. x + 0 returns x unchanged, and a zero sum is always +0.
- R10: If the normalized exponent reaches 255 or more, the output is the signed infinity pattern: exponent 255, fraction 0. If it falls to 0 or below, the output is +0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Operand pair is presented this cycle |
| opA | input | 32 | First operand |
| opB | input | 32 | Second operand |
| outValid | output | 1 | Result slot holds a completed operation |
| outSum | output | 32 | Truncated sum |
| outInexact | output | 1 | A 1 bit was lost during exponent alignment |
| outBad | output | 1 | An operand was neither zero nor normalized |

## Verification
Directed pairs cover several cases, and each one separates a different way of getting the result wrong:
- same-sign sums with and without a carry out;
- opposite-sign sums of either sign, including exact cancellation;
- deep left normalization after a near cancellation;
- alignment shifts of 23, 24 and 30 places, which place the inexact boundary;
- zero operands, illegal encodings, and exponent overflow and underflow.

A long back-to-back stream follows, with random operands whose exponents lie close together and with random idle slots. It shows that the three operations in flight never mix their fields. A reset applied while operations are in flight shows that those operations are discarded.

// File: rtl/fpAddPkg.sv
package fpAddPkg;

  // Load strobes issued by the control to each datapath stage register
  typedef struct packed {
    logic ldAlign;
    logic ldAdd;
    logic ldNorm;
  } stageStrobe_t;

endpackage

// File: rtl/fpAddCtrl.sv
module fpAddCtrl
  import fpAddPkg::*;
(
  input  logic         clk,
  input  logic         rst,
  input  logic         inValid,
  output stageStrobe_t stb,
  output logic         outValid
);

  logic alignV, addV, normV;

  always_ff @(posedge clk) begin
    if (rst) begin
      alignV <= 1'b0;
      addV   <= 1'b0;
      normV  <= 1'b0;
    end else begin
      alignV <= inValid;
      addV   <= alignV;
      normV  <= addV;
    end
  end

  // Each stage register loads only when an operation moves into it
  always_comb begin
    stb.ldAlign = inValid;
    stb.ldAdd   = alignV;
    stb.ldNorm  = addV;
  end

  assign outValid = normV;

endmodule

// File: rtl/fpAddDatapath.sv
module fpAddDatapath
  import fpAddPkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                        clk,
  input  stageStrobe_t                stb,
  input  logic [EXP_W+FRAC_W:0]       opA,
  input  logic [EXP_W+FRAC_W:0]       opB,
  output logic [EXP_W+FRAC_W:0]       sumOut,
  output logic                        inexactOut,
  output logic                        badOut
);

  localparam int WORD_W = 1 + EXP_W + FRAC_W;
  localparam int MAN_W  = FRAC_W + 1;
  localparam int SUM_W  = MAN_W + 1;
  localparam int LZ_W   = $clog2(MAN_W + 1);
  localparam int EW_W   = EXP_W + 2;
  localparam logic [EXP_W-1:0] EXP_ALL1   = {EXP_W{1'b1}};
  localparam logic [EXP_W-1:0] SHIFT_ALL  = EXP_W'(MAN_W);
  localparam logic signed [EW_W-1:0] EXP_TOP = EW_W'((1 << EXP_W) - 1);

  // ---------------- stage 1: exponent alignment ----------------
  logic             signA, signB;
  logic [EXP_W-1:0] expA, expB;
  logic [MAN_W-1:0] manA, manB;
  logic             badA, badB, swapOps;
  logic             bigSign;
  logic [EXP_W-1:0] bigExp, smlExp, expDiff;
  logic [MAN_W-1:0] bigMan, smlMan, smlShifted, lostMask;
  logic             lostAny;

  assign signA = opA[WORD_W-1];
  assign signB = opB[WORD_W-1];
  assign expA  = opA[WORD_W-2 -: EXP_W];
  assign expB  = opB[WORD_W-2 -: EXP_W];
  assign manA  = {expA != '0, opA[FRAC_W-1:0]};
  assign manB  = {expB != '0, opB[FRAC_W-1:0]};
  assign badA  = (expA == EXP_ALL1) || ((expA == '0) && (opA[FRAC_W-1:0] != '0));
  assign badB  = (expB == EXP_ALL1) || ((expB == '0) && (opB[FRAC_W-1:0] != '0));
  assign swapOps = (expB > expA) || ((expB == expA) && (manB > manA));

  always_comb begin
    if (swapOps) begin
      bigSign = signB; bigExp = expB; bigMan = manB;
      smlExp  = expA;  smlMan = manA;
    end else begin
      bigSign = signA; bigExp = expA; bigMan = manA;
      smlExp  = expB;  smlMan = manB;
    end
    expDiff  = bigExp - smlExp;
    lostMask = ~({MAN_W{1'b1}} << expDiff);
    if (expDiff >= SHIFT_ALL) begin
      smlShifted = '0;
      lostAny    = (smlMan != '0);
    end else begin
      smlShifted = smlMan >> expDiff;
      lostAny    = ((smlMan & lostMask) != '0);
    end
  end

  logic             alBad, alSign, alSub, alLost;
  logic [EXP_W-1:0] alExp;
  logic [MAN_W-1:0] alBig, alSml;

  always_ff @(posedge clk) begin
    if (stb.ldAlign) begin
      alBad  <= badA | badB;
      alSign <= bigSign;
      alSub  <= signA ^ signB;
      alLost <= lostAny;
      alExp  <= bigExp;
      alBig  <= bigMan;
      alSml  <= smlShifted;
    end
  end

  // ---------------- stage 2: fraction addition ----------------
  logic [SUM_W-1:0] rawSum;

  assign rawSum = alSub ? ({1'b0, alBig} - {1'b0, alSml})
                        : ({1'b0, alBig} + {1'b0, alSml});

  logic             adBad, adSign, adLost;
  logic [EXP_W-1:0] adExp;
  logic [SUM_W-1:0] adSum;

  always_ff @(posedge clk) begin
    if (stb.ldAdd) begin
      adBad  <= alBad;
      adSign <= alSign;
      adLost <= alLost;
      adExp  <= alExp;
      adSum  <= rawSum;
    end
  end

  // ---------------- stage 3: normalization ----------------
  logic [LZ_W-1:0]         lzCount;
  logic                    lzFound;
  logic signed [EW_W-1:0]  expWide, expNew;
  logic [FRAC_W-1:0]       fracNew;
  logic [WORD_W-1:0]       normWord;

  always_comb begin
    lzCount = '0;
    lzFound = 1'b0;
    for (int i = MAN_W - 1; i >= 0; i--) begin
      if (!lzFound && adSum[i]) begin
        lzCount = LZ_W'(MAN_W - 1 - i);
        lzFound = 1'b1;
      end
    end
  end

  always_comb begin
    expWide = $signed({2'b00, adExp});
    if (adSum[SUM_W-1]) begin
      expNew  = expWide + EW_W'(1);
      fracNew = adSum[FRAC_W:1];
    end else begin
      expNew  = expWide - $signed({{(EW_W-LZ_W){1'b0}}, lzCount});
      fracNew = FRAC_W'(adSum[MAN_W-1:0] << lzCount);
    end

    if (adBad || (adSum == '0) || (expNew <= 0)) begin
      normWord = '0;
    end else if (expNew >= EXP_TOP) begin
      normWord = {adSign, EXP_ALL1, {FRAC_W{1'b0}}};
    end else begin
      normWord = {adSign, expNew[EXP_W-1:0], fracNew};
    end
  end

  always_ff @(posedge clk) begin
    if (stb.ldNorm) begin
      sumOut     <= normWord;
      inexactOut <= adLost & ~adBad;
      badOut     <= adBad;
    end
  end

endmodule

// File: rtl/fpAddPipe.sv
module fpAddPipe
  import fpAddPkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  inValid,
  input  logic [EXP_W+FRAC_W:0] opA,
  input  logic [EXP_W+FRAC_W:0] opB,
  output logic                  outValid,
  output logic [EXP_W+FRAC_W:0] outSum,
  output logic                  outInexact,
  output logic                  outBad
);

  stageStrobe_t stb;
  logic dpInexact, dpBad;

  fpAddCtrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .stb      (stb),
    .outValid (outValid)
  );

  fpAddDatapath #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_dp (
    .clk        (clk),
    .stb        (stb),
    .opA        (opA),
    .opB        (opB),
    .sumOut     (outSum),
    .inexactOut (dpInexact),
    .badOut     (dpBad)
  );

  assign outInexact = outValid & dpInexact;
  assign outBad     = outValid & dpBad;

endmodule

// File: rtl/fpAddPipeChk.sv
module fpAddPipeChk #(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23
) (
  input logic                  clk,
  input logic                  rst,
  input logic                  inValid,
  input logic [EXP_W-1:0]      expA,
  input logic [EXP_W-1:0]      expB,
  input logic                  outValid,
  input logic [EXP_W+FRAC_W:0] outSum,
  input logic                  outInexact,
  input logic                  outBad
);

  localparam int WORD_W = 1 + EXP_W + FRAC_W;

  logic [1:0] sinceRst;

  always_ff @(posedge clk) begin
    if (rst)                  sinceRst <= 2'd0;
    else if (sinceRst != 2'd3) sinceRst <= sinceRst + 2'd1;
  end

  // R1
  latency_three_chk: assert property (@(posedge clk) disable iff (rst)
    (sinceRst == 2'd3) |-> (outValid == $past(inValid, 3)));

  // R2
  reset_flush_chk: assert property (@(posedge clk)
    rst |=> !outValid);

  // R8
  bad_gives_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && outBad) |-> ((outSum == '0) && !outInexact));

  // R10
  no_denormal_out_chk: assert property (@(posedge clk) disable iff (rst)
    (outValid && (outSum[WORD_W-2 -: EXP_W] == '0)) |-> (outSum == '0));

  // R6
  equal_exp_exact_chk: assert property (@(posedge clk) disable iff (rst)
    ((sinceRst == 2'd3) && outValid && ($past(expA, 3) == $past(expB, 3))) |-> !outInexact);

endmodule

bind fpAddPipe fpAddPipeChk #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .inValid    (inValid),
  .expA       (opA[EXP_W+FRAC_W-1 -: EXP_W]),
  .expB       (opB[EXP_W+FRAC_W-1 -: EXP_W]),
  .outValid   (outValid),
  .outSum     (outSum),
  .outInexact (outInexact),
  .outBad     (outBad)
);

// File: tb/fpAddPipe_tb.sv
`timescale 1ns/1ps
module fpAddPipe_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        outValid;
  logic [31:0] outSum;
  logic        outInexact;
  logic        outBad;

  int nChecks = 0;
  int nFails  = 0;

  always #5 clk = ~clk;

  fpAddPipe u_dut (
    .clk(clk), .rst(rst), .inValid(inValid), .opA(opA), .opB(opB),
    .outValid(outValid), .outSum(outSum), .outInexact(outInexact), .outBad(outBad)
  );

  typedef struct {
    logic        v;
    logic [31:0] s;
    logic        inx;
    logic        bad;
    string       tag;
  } expect_t;

  expect_t pend[$];

  // Behavioural reference from the requirements
  function automatic void refAdd(input logic [31:0] a, input logic [31:0] b,
                                 output logic [31:0] s, output logic inx, output logic bad);
    int ea, eb, ex, d, e;
    longint ma, mb, mx, kept, r;
    logic sa, sb, sx;
    ea = int'(a[30:23]); eb = int'(b[30:23]);
    sa = a[31]; sb = b[31];
    bad = (ea == 255) || (ea == 0 && a[22:0] != 0) || (eb == 255) || (eb == 0 && b[22:0] != 0);
    s = 32'h0; inx = 1'b0;
    if (bad) return;
    ma = (ea == 0) ? 0 : (longint'(1) << 23) + longint'(a[22:0]);
    mb = (eb == 0) ? 0 : (longint'(1) << 23) + longint'(b[22:0]);
    if (eb > ea || (eb == ea && mb > ma)) begin
      ex = ea; ea = eb; eb = ex;
      mx = ma; ma = mb; mb = mx;
      sx = sa; sa = sb; sb = sx;
    end
    d = ea - eb;
    if (d >= 24) begin
      kept = 0;
      inx  = (mb != 0);
    end else begin
      kept = mb >> d;
      inx  = ((kept << d) != mb);
    end
    r = (sa == sb) ? ma + kept : ma - kept;
    e = ea;
    if (r == 0) begin
      s = 32'h0;
      return;
    end
    while (r >= (longint'(1) << 24)) begin r = r >> 1; e = e + 1; end
    while (r <  (longint'(1) << 23)) begin r = r << 1; e = e - 1; end
    if (e >= 255)    s = {sa, 8'hFF, 23'h0};
    else if (e <= 0) s = 32'h0;
    else             s = {sa, 8'(e), 23'(r)};
  endfunction

  task automatic compareOut();
    expect_t x;
    if (pend.size() < 3) return;
    x = pend.pop_front();
    nChecks++;
    if (outValid !== x.v || outInexact !== (x.v & x.inx) || outBad !== (x.v & x.bad) ||
        (x.v && outSum !== x.s)) begin
      nFails++;
      $display("FAIL %s: got v=%b sum=%h inx=%b bad=%b, expected v=%b sum=%h inx=%b bad=%b",
               x.tag, outValid, outSum, outInexact, outBad,
               x.v, x.s, x.v & x.inx, x.v & x.bad);
    end
  endtask

  task automatic cycle(input logic r, input logic v, input logic [31:0] a,
                       input logic [31:0] b, input string tag);
    expect_t x;
    @(negedge clk);
    compareOut();
    rst = r; inValid = v; opA = a; opB = b;
    if (r) begin
      foreach (pend[i]) begin
        pend[i].v = 1'b0;
        pend[i].tag = "R2";
      end
    end
    x.v = v & ~r;
    x.tag = tag;
    refAdd(a, b, x.s, x.inx, x.bad);
    pend.push_back(x);
  endtask

  task automatic op(input logic [31:0] a, input logic [31:0] b, input string tag);
    cycle(1'b0, 1'b1, a, b, tag);
  endtask

  // Directed check of the reference itself against hand-worked values
  task automatic known(input logic [31:0] a, input logic [31:0] b, input logic [31:0] s,
                       input logic inx, input string tag);
    logic [31:0] gs; logic gi, gb;
    refAdd(a, b, gs, gi, gb);
    if (gs !== s || gi !== inx) begin
      $display("FAIL %s: model table mismatch got %h/%b expected %h/%b", tag, gs, gi, s, inx);
      nFails++;
    end
    op(a, b, tag);
  endtask

  initial begin
    #2_000_000;
    nFails++;
    $display("FAIL watchdog: run did not finish, got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

  initial begin
    // R2: reset state
    for (int i = 0; i < 4; i++) cycle(1'b1, 1'b0, '0, '0, "R2");
    for (int i = 0; i < 3; i++) cycle(1'b0, 1'b0, '0, '0, "R2");

    // R3 same sign, with and without carry
    known(32'h3F800000, 32'h3F800000, 32'h40000000, 1'b0, "R3");
    known(32'h3FC00000, 32'h3E800000, 32'h3FE00000, 1'b0, "R3");
    known(32'h3FFFFFFF, 32'h3FFFFFFF, 32'h407FFFFF, 1'b0, "R3");
    // R4 opposite signs, cancellation
    known(32'h3F800000, 32'hC0400000, 32'hC0000000, 1'b0, "R4");
    known(32'h3F800000, 32'hBF800000, 32'h00000000, 1'b0, "R4");
    // R7 deep left normalization
    known(32'h3F800001, 32'hBF800000, 32'h34000000, 1'b0, "R7");
    // R5 / R6 alignment boundaries
    known(32'h3F800000, 32'h34000000, 32'h3F800001, 1'b0, "R5");
    known(32'h3F800000, 32'h34400000, 32'h3F800001, 1'b1, "R6");
    known(32'h33800000, 32'h3F800000, 32'h3F800000, 1'b1, "R6");
    known(32'h3F800000, 32'h30800000, 32'h3F800000, 1'b1, "R6");
    // R9 zeros
    known(32'h00000000, 32'h3FC00000, 32'h3FC00000, 1'b0, "R9");
    known(32'h80000000, 32'h80000000, 32'h00000000, 1'b0, "R9");
    // R8 illegal encodings
    known(32'h7F800000, 32'h3F800000, 32'h00000000, 1'b0, "R8");
    known(32'h3F800000, 32'h00000001, 32'h00000000, 1'b0, "R8");
    // R10 overflow and underflow
    known(32'h7F7FFFFF, 32'h7F7FFFFF, 32'h7F800000, 1'b0, "R10");
    known(32'hFF7FFFFF, 32'hFF7FFFFF, 32'hFF800000, 1'b0, "R10");
    known(32'h00800001, 32'h80800000, 32'h00000000, 1'b0, "R10");

    // R1: back-to-back random stream with idle slots
    for (int i = 0; i < 400; i++) begin
      logic [31:0] a, b;
      a = {1'($urandom), 8'(100 + $urandom_range(0, 40)), 23'($urandom)};
      b = {1'($urandom), 8'(100 + $urandom_range(0, 40)), 23'($urandom)};
      cycle(1'b0, ($urandom_range(0, 4) != 0), a, b, "R1");
    end

    // R2: reset with operations in flight
    op(32'h3F800000, 32'h3F800000, "R2");
    op(32'h40000000, 32'h3F800000, "R2");
    cycle(1'b1, 1'b1, 32'h3F800000, 32'h3F800000, "R2");
    for (int i = 0; i < 5; i++) cycle(1'b0, 1'b0, '0, '0, "R2");

    $display("[TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end

endmodule